// File: doc/BRIEF.md
# Code Protection Security Gate

This block holds the one-byte security setting of a microcontroller's on-chip flash and applies it to every path that could expose internal code. An external programmer reads the flash array, the two fixed identification bytes and the security byte through a gated read port. The CPU's table-lookup reads pass through a second gate that considers where the requesting instruction was fetched from. Bytes leaving on the external address/data bus go through a scrambler. The oscillator amplifier gain select is also driven from this byte.

Security bits read as 1 when blank and take effect at 0. The programmer can only clear bits. A chip-wide erase is the only way back to the blank value. The scrambling itself is a placeholder XOR with a parameter key.

Top module: `code_sec_gate`

## Requirements
- R1: After synchronous reset the security byte is FFh. `osc_full_gain` is 1. `prog_rd_valid`, `tbl_valid`, `violation` and `bus_out` are 0.
- R2: A programmer write (`prog_wr_en`) sets the byte to old AND (data OR 78h). Bits 3..6 therefore stay 1, and a bit once cleared is never set again by a write.
- R3: `erase_all` returns the byte to FFh on the next edge. It takes priority over a write in the same cycle.
- R4: While bit 0 is 1, a programmer read returns its result one cycle after `prog_rd_req`, with `prog_rd_valid` high for that cycle. The `prog_rd_space` codes are: 0 returns `flash_rdata`, 1 returns vendor code DAh, 2 returns the device code parameter, and 3 returns the security byte.
- R5: While bit 0 is 0, every programmer read returns FFh and raises `violation`.
- R6: A table read fetched from internal memory (`tbl_fetch_ext`=0) returns `tbl_rdata` one cycle later, whatever bit 1 holds.
- R7: A table read fetched from external memory that targets internal memory (`tbl_target_int`=1) returns FFh and raises `violation` when bit 1 is 0. In every other case it returns `tbl_rdata`.
- R8: `bus_out` is `bus_in` delayed one cycle. It is XORed with the key (A5h by default) while bit 2 is 0.
- R9: `osc_full_gain` equals bit 7 (0 selects half gain).
- R10: `prog_rd_valid`, `tbl_valid` and `violation` are single-cycle responses. They are low in any cycle that follows no request.
- R11: A programmer read issued in the same cycle as a write is judged on the byte as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_wr_en | input | 1 | Programmer write strobe for the security byte |
| prog_wr_data | input | 8 | Byte written; only its 0 bits take effect |
| erase_all | input | 1 | Whole-chip erase strobe |
| prog_rd_req | input | 1 | Programmer read request |
| prog_rd_space | input | 2 | Read space: 0 flash, 1 vendor, 2 device, 3 security byte |
| flash_rdata | input | DATA_W | Flash array data for the programmer read |
| prog_rd_data | output | DATA_W | Programmer read result |
| prog_rd_valid | output | 1 | Programmer read result valid |
| tbl_req | input | 1 | CPU table-read request |
| tbl_fetch_ext | input | 1 | Requesting instruction came from external memory |
| tbl_target_int | input | 1 | Table read addresses internal code |
| tbl_rdata | input | DATA_W | Data from the addressed code memory |
| tbl_data | output | DATA_W | Table-read result |
| tbl_valid | output | 1 | Table-read result valid |
| bus_in | input | DATA_W | Byte to be driven on the external bus |
| bus_out | output | DATA_W | Possibly scrambled bus byte |
| osc_full_gain | output | 1 | Oscillator amplifier full-gain select |
| violation | output | 1 | A blocked read was answered this cycle |

## Verification
Two collisions can occur in one cycle, and the bench provokes both. In the first, the programmer clears the lock bit while it issues a read in the same cycle. The read must still return the flash byte with no violation, and the read that follows must return FFh with a violation. In the second, `erase_all` and a clearing write arrive together. Reading the security byte afterwards must show FFh. Around these cases the bench sweeps all 256 write values from a blank byte and checks every read space, every fetch/target combination and both bus polarities against a model.

// File: rtl/csg_pkg.sv
package csg_pkg;
  localparam int unsigned SEC_W    = 8;
  localparam int unsigned BIT_LOCK = 0;
  localparam int unsigned BIT_TBL  = 1;
  localparam int unsigned BIT_ENC  = 2;
  localparam int unsigned BIT_OSC  = 7;
  localparam logic [SEC_W-1:0] RSVD_MASK   = 8'h78;
  localparam logic [SEC_W-1:0] BLANK_BYTE  = 8'hFF;
  localparam logic [SEC_W-1:0] VENDOR_CODE = 8'hDA;

  typedef enum logic [1:0] {
    SP_FLASH  = 2'd0,
    SP_VENDOR = 2'd1,
    SP_DEVICE = 2'd2,
    SP_SECB   = 2'd3
  } rd_space_e;
endpackage

// File: rtl/csg_sec_store.sv
module csg_sec_store
  import csg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEC_W-1:0] wr_data,
  input  logic             erase_all,
  output logic [SEC_W-1:0] sec_q
);
  always_ff @(posedge clk) begin
    if (rst || erase_all) begin
      sec_q <= BLANK_BYTE;
    end else if (wr_en) begin
      sec_q <= sec_q & (wr_data | RSVD_MASK);
    end
  end

  AST_ONLY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !erase_all |=> ((sec_q & ~$past(sec_q)) == '0)); // R2
  AST_RSVD_HIGH: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((sec_q & RSVD_MASK) == RSVD_MASK)); // R2
  AST_ERASE_BLANK: assert property (@(posedge clk) disable iff (rst)
    erase_all |=> (sec_q == BLANK_BYTE)); // R3
endmodule

// File: rtl/csg_prog_gate.sv
module csg_prog_gate
  import csg_pkg::*;
#(
  parameter int unsigned     DATA_W      = 8,
  parameter logic [SEC_W-1:0] DEVICE_CODE = 8'h3C
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [1:0]        rd_space,
  input  logic [DATA_W-1:0] flash_rdata,
  input  logic [SEC_W-1:0]  sec_byte,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              blocked
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic              unlocked;
  logic [DATA_W-1:0] sel_data;

  assign unlocked = sec_byte[BIT_LOCK];

  always_comb begin
    case (rd_space_e'(rd_space))
      SP_FLASH:  sel_data = flash_rdata;
      SP_VENDOR: sel_data = DATA_W'(VENDOR_CODE);
      SP_DEVICE: sel_data = DATA_W'(DEVICE_CODE);
      default:   sel_data = DATA_W'(sec_byte);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      blocked  <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      blocked  <= rd_req && !unlocked;
      if (rd_req) rd_data <= unlocked ? sel_data : ALL_ONES;
    end
  end

  AST_LOCKED_FF: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !sec_byte[BIT_LOCK]) |=> (rd_data == ALL_ONES && blocked)); // R5
  AST_FLASH_PASS: assert property (@(posedge clk) disable iff (rst)
    (rd_req && sec_byte[BIT_LOCK] && rd_space == 2'd0) |=> (rd_data == $past(flash_rdata) && !blocked)); // R4
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (!rd_valid && !blocked)); // R10
endmodule

// File: rtl/csg_tbl_gate.sv
module csg_tbl_gate
  import csg_pkg::*;
#(
  parameter int unsigned DATA_W = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              fetch_ext,
  input  logic              target_int,
  input  logic [DATA_W-1:0] code_rdata,
  input  logic              tbl_open,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic              denied
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic deny_now;
  assign deny_now = req && fetch_ext && target_int && !tbl_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      data   <= '0;
      valid  <= 1'b0;
      denied <= 1'b0;
    end else begin
      valid  <= req;
      denied <= deny_now;
      if (req) data <= deny_now ? ALL_ONES : code_rdata;
    end
  end

  AST_INT_FETCH_FREE: assert property (@(posedge clk) disable iff (rst)
    (req && !fetch_ext) |=> (data == $past(code_rdata) && !denied)); // R6
  AST_EXT_DENY: assert property (@(posedge clk) disable iff (rst)
    (req && fetch_ext && target_int && !tbl_open) |=> (data == ALL_ONES && denied)); // R7
  AST_TBL_PULSE: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!valid && !denied)); // R10
endmodule

// File: rtl/csg_bus_scramble.sv
module csg_bus_scramble #(
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY    = 8'hA5
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_off,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] mixed;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_bit
      if (KEY[gi]) begin : g_flip
        assign mixed[gi] = din[gi] ^ !enc_off;
      end else begin : g_keep
        assign mixed[gi] = din[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= mixed;
  end

  AST_CLEAR_PASS: assert property (@(posedge clk) disable iff (rst)
    enc_off |=> (dout == $past(din))); // R8
  AST_ENC_XOR: assert property (@(posedge clk) disable iff (rst)
    !enc_off |=> (dout == ($past(din) ^ KEY))); // R8
endmodule

// File: rtl/code_sec_gate.sv
module code_sec_gate
  import csg_pkg::*;
#(
  parameter int unsigned       DATA_W      = 8,
  parameter logic [SEC_W-1:0]  DEVICE_CODE = 8'h3C,
  parameter logic [DATA_W-1:0] ENC_KEY     = 8'hA5
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_wr_en,
  input  logic [7:0]        prog_wr_data,
  input  logic              erase_all,
  input  logic              prog_rd_req,
  input  logic [1:0]        prog_rd_space,
  input  logic [DATA_W-1:0] flash_rdata,
  output logic [DATA_W-1:0] prog_rd_data,
  output logic              prog_rd_valid,
  input  logic              tbl_req,
  input  logic              tbl_fetch_ext,
  input  logic              tbl_target_int,
  input  logic [DATA_W-1:0] tbl_rdata,
  output logic [DATA_W-1:0] tbl_data,
  output logic              tbl_valid,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              osc_full_gain,
  output logic              violation
);
  logic [SEC_W-1:0] sec_q;
  logic             prog_blocked;
  logic             tbl_denied;

  csg_sec_store u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (prog_wr_en),
    .wr_data   (prog_wr_data),
    .erase_all (erase_all),
    .sec_q     (sec_q)
  );

  csg_prog_gate #(.DATA_W(DATA_W), .DEVICE_CODE(DEVICE_CODE)) u_prog (
    .clk         (clk),
    .rst         (rst),
    .rd_req      (prog_rd_req),
    .rd_space    (prog_rd_space),
    .flash_rdata (flash_rdata),
    .sec_byte    (sec_q),
    .rd_data     (prog_rd_data),
    .rd_valid    (prog_rd_valid),
    .blocked     (prog_blocked)
  );

  csg_tbl_gate #(.DATA_W(DATA_W)) u_tbl (
    .clk        (clk),
    .rst        (rst),
    .req        (tbl_req),
    .fetch_ext  (tbl_fetch_ext),
    .target_int (tbl_target_int),
    .code_rdata (tbl_rdata),
    .tbl_open   (sec_q[BIT_TBL]),
    .data       (tbl_data),
    .valid      (tbl_valid),
    .denied     (tbl_denied)
  );

  csg_bus_scramble #(.DATA_W(DATA_W), .KEY(ENC_KEY)) u_scr (
    .clk     (clk),
    .rst     (rst),
    .enc_off (sec_q[BIT_ENC]),
    .din     (bus_in),
    .dout    (bus_out)
  );

  assign osc_full_gain = sec_q[BIT_OSC];
  assign violation     = prog_blocked | tbl_denied;

  AST_VIOL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (!prog_rd_req && !tbl_req) |=> !violation); // R10
  AST_GAIN_AFTER_ERASE: assert property (@(posedge clk) disable iff (rst)
    erase_all |=> osc_full_gain); // R9
endmodule

// File: tb/tb_code_sec_gate.sv
`timescale 1ns/1ps
module tb_code_sec_gate;
  localparam logic [7:0] KEY = 8'hA5;
  localparam logic [7:0] DEV = 8'h3C;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       prog_wr_en = 1'b0;
  logic [7:0] prog_wr_data = '0;
  logic       erase_all = 1'b0;
  logic       prog_rd_req = 1'b0;
  logic [1:0] prog_rd_space = '0;
  logic [7:0] flash_rdata = '0;
  logic [7:0] prog_rd_data;
  logic       prog_rd_valid;
  logic       tbl_req = 1'b0;
  logic       tbl_fetch_ext = 1'b0;
  logic       tbl_target_int = 1'b0;
  logic [7:0] tbl_rdata = '0;
  logic [7:0] tbl_data;
  logic       tbl_valid;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out;
  logic       osc_full_gain;
  logic       violation;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_sec;

  always #2 clk = ~clk;

  code_sec_gate dut (.*);

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0; exp_sec = 8'hFF;
  endtask

  task automatic prog_write(input logic [7:0] v);
    prog_wr_en = 1'b1; prog_wr_data = v; tick(); prog_wr_en = 1'b0;
    exp_sec = exp_sec & (v | 8'h78);
  endtask

  task automatic prog_read(input logic [1:0] sp, input logic [7:0] fl, input string req);
    logic [7:0] e;
    prog_rd_req = 1'b1; prog_rd_space = sp; flash_rdata = fl; tick(); prog_rd_req = 1'b0;
    if (!exp_sec[0]) e = 8'hFF;
    else case (sp)
      2'd0: e = fl; 2'd1: e = 8'hDA; 2'd2: e = DEV; default: e = exp_sec;
    endcase
    chk(prog_rd_data == e, req, prog_rd_data, e);
    chk(prog_rd_valid && (violation == !exp_sec[0]), "R5 valid/violation", {6'd0, prog_rd_valid, violation}, {6'd0, 1'b1, !exp_sec[0]});
  endtask

  task automatic tbl_read(input bit ext, input bit tint, input logic [7:0] d);
    bit deny;
    logic [7:0] e;
    deny = ext && tint && !exp_sec[1];
    e = deny ? 8'hFF : d;
    tbl_req = 1'b1; tbl_fetch_ext = ext; tbl_target_int = tint; tbl_rdata = d; tick(); tbl_req = 1'b0;
    chk(tbl_data == e && tbl_valid && violation == deny, ext ? "R7 table read" : "R6 table read", tbl_data, e);
  endtask

  task automatic bus_chk(input logic [7:0] d);
    logic [7:0] e;
    e = exp_sec[2] ? d : (d ^ KEY);
    bus_in = d; tick();
    chk(bus_out == e, "R8 bus scramble", bus_out, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(osc_full_gain == 1'b1, "R1 gain", {7'd0, osc_full_gain}, 8'h01);
    chk(!prog_rd_valid && !tbl_valid && !violation, "R1 strobes", {5'd0, prog_rd_valid, tbl_valid, violation}, 8'h00);
    chk(bus_out == 8'h00, "R1 bus", bus_out, 8'h00);
    prog_read(2'd3, 8'h00, "R1 blank byte");

    // R2 R4 R5 R6 R7 R8 R9: sweep every write value from a blank byte
    for (int v = 0; v < 256; v++) begin
      do_reset();
      prog_write(8'(v));
      chk(osc_full_gain == exp_sec[7], "R9 gain", {7'd0, osc_full_gain}, {7'd0, exp_sec[7]});
      prog_read(2'd3, 8'h00, "R2 security byte");
      prog_read(2'd0, 8'(v) ^ 8'h5A, "R4 flash read");
      prog_read(2'd1, 8'h00, "R4 vendor code");
      prog_read(2'd2, 8'h00, "R4 device code");
      for (int c = 0; c < 4; c++) tbl_read(c[1], c[0], 8'(v) ^ 8'h33);
      bus_chk(8'(v));
      bus_chk(~8'(v));
    end

    // R2 monotonic: a 1 written never restores a cleared bit
    for (int a = 0; a < 8; a++) begin
      do_reset();
      prog_write(8'hFF ^ (8'h01 << a) | 8'h01);
      prog_write(8'hFF);
      prog_read(2'd3, 8'h00, "R2 no set");
    end

    // R3 erase restores, and wins over a same-cycle write
    do_reset();
    prog_write(8'h00);
    prog_read(2'd0, 8'h12, "R5 locked");
    erase_all = 1'b1; prog_wr_en = 1'b1; prog_wr_data = 8'h00; tick();
    erase_all = 1'b0; prog_wr_en = 1'b0; exp_sec = 8'hFF;
    prog_read(2'd3, 8'h00, "R3 erase priority");
    chk(osc_full_gain, "R3 gain back", {7'd0, osc_full_gain}, 8'h01);

    // R10 strobes drop after a request
    prog_read(2'd0, 8'h44, "R4 flash");
    tick();
    chk(!prog_rd_valid && !tbl_valid && !violation, "R10 pulse", {5'd0, prog_rd_valid, tbl_valid, violation}, 8'h00);

    // R11 lock write in same cycle as a read: read sees old byte
    do_reset();
    prog_wr_en = 1'b1; prog_wr_data = 8'hFE;
    prog_rd_req = 1'b1; prog_rd_space = 2'd0; flash_rdata = 8'h9C; tick();
    prog_wr_en = 1'b0; prog_rd_req = 1'b0;
    chk(prog_rd_data == 8'h9C && !violation, "R11 same-cycle read", prog_rd_data, 8'h9C);
    exp_sec = 8'hFE;
    prog_read(2'd0, 8'h9C, "R11 following read");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule